// File: doc/BRIEF.md
# Auto-Reload Multi-Block DMA Channel

This block is one DMA channel that copies a block of data items from a source region to a destination region, then restores its working addresses and control from the values software programmed and copies the same block again. The repetition goes on until software clears the reload settings. From then on, the block in progress is the final one. Every completed block raises a block-complete status. The final block also raises transfer-complete status and drops the channel's active flag, so software can poll that flag or wait on the interrupt.

Software drives a simple write-only register port. Through it, software sets a global enable, the two start addresses, a control word and a configuration word, and it also uses this port to start the channel, clear status and issue software requests. Each side can be paced in one of two ways. In hardware mode, a request line gates each transfer and the channel answers with a one-cycle acknowledge. In software mode, a request bit set through the register port gates each transfer. Each item moves as one read beat followed by one write beat on a single memory master port. When interrupts are enabled and the block interrupt is unmasked, the channel halts after each block until software clears block-complete.

Top module: `dmar_reload_chan`

## Requirements
- R1: Writing 1 to bit 0 of register 5 starts the channel only while bit 0 of register 0 (global enable) is 1. Otherwise the write is ignored, `ch_active` stays 0 and no memory access occurs.
- R2: Control word (register 3) bits [1:0] and [3:2] give the source and destination item width (code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). `mem_size` carries the source code on reads and the destination code on writes.
- R3: Control bits [5:4] (source) and [7:6] (destination) pick the address mode: 0 = increment by the item width in bytes, 1 = decrement by it, 2 or 3 = fixed.
- R4: In configuration word (register 4), bit 0 (source) and bit 1 (destination) select hardware pacing with 0 and software pacing with 1. A software side is paced by bits 0 and 1 of register 7, which stay pending until used, and its request line is ignored. An item starts only when both sides have a request.
- R5: A hardware-paced side gets one single-cycle acknowledge after each item's write completes. A software-paced side gets none.
- R6: At block end, when configuration bits 2 and 3 (reload) are both 1 and the link register (register 8) is 0, the addresses, control and item count return to their programmed start values. Block-complete (`irq_block`) is then set and the next block begins.
- R7: When control bit 8 (interrupt enable) and configuration bit 4 (block interrupt unmask) are both 1, the channel makes no memory access after a reloading block end until block-complete is cleared. The read of the next item is issued two cycles after the clearing write.
- R8: A block end without reload (either reload bit 0 or register 8 nonzero) sets both `irq_block` and `irq_xfer` and clears `ch_active`.
- R9: Writing register 6 clears `irq_block` for bit 0 = 1 and `irq_xfer` for bit 1 = 1. Zero bits leave status unchanged.
- R10: After reset the channel is inactive, both status outputs are 0 and no memory request is made.
- R11: Each item is one read at the source address followed by one write at the destination address. Each beat is held until `mem_ready`, and the written data equals the data read.
- R12: A block holds the number of items given in control bits [16 +: CNT_W]. A value of 0 means 2^CNT_W items.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Beat byte address |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Beat completes this cycle |
| src_hreq | input | 1 | Source hardware request |
| src_hack | output | 1 | Source acknowledge pulse |
| dst_hreq | input | 1 | Destination hardware request |
| dst_hack | output | 1 | Destination acknowledge pulse |
| ch_active | output | 1 | Channel enabled and running |
| irq_block | output | 1 | Block-complete status |
| irq_xfer | output | 1 | Transfer-complete status |

## Verification
The bench builds the channel with a 16-bit address, 32-bit data and a 6-bit item count. Blocks of two to four items therefore finish in a few dozen cycles, so runs of three reloaded blocks, a halt after a block and the clearing write that resumes it, and last-block decisions forced by the link register all fit in a short run. The narrow address keeps the memory model a pure function of the address. Every read and write address, size and data value can then be predicted, including decrementing halfword and fixed byte addressing.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD,
        ST_WR,
        ST_ACK,
        ST_END,
        ST_STALL
    } chan_state_e;

    localparam logic [3:0] RG_GEN   = 4'd0;
    localparam logic [3:0] RG_SRC   = 4'd1;
    localparam logic [3:0] RG_DST   = 4'd2;
    localparam logic [3:0] RG_CTL   = 4'd3;
    localparam logic [3:0] RG_CFG   = 4'd4;
    localparam logic [3:0] RG_CHEN  = 4'd5;
    localparam logic [3:0] RG_ICLR  = 4'd6;
    localparam logic [3:0] RG_SWREQ = 4'd7;
    localparam logic [3:0] RG_LINK  = 4'd8;

    localparam logic [1:0] AM_INC = 2'd0;
    localparam logic [1:0] AM_DEC = 2'd1;

    typedef struct packed {
        logic [1:0] src_w;
        logic [1:0] dst_w;
        logic [1:0] src_m;
        logic [1:0] dst_m;
        logic       int_en;
    } ctl_t;

    typedef struct packed {
        logic blk_unmask;
        logic rl_dst;
        logic rl_src;
        logic dst_sw;
        logic src_sw;
    } cfg_t;

    function automatic logic [2:0] beat_bytes(input logic [1:0] code);
        case (code)
            2'd0:    beat_bytes = 3'd1;
            2'd1:    beat_bytes = 3'd2;
            default: beat_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmar_regs.sv
module dmar_regs
    import dmar_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [3:0]       waddr,
    input  logic [31:0]      wdata,
    input  logic             set_blk,
    input  logic             set_xfer,
    input  logic             use_sw_src,
    input  logic             use_sw_dst,
    output logic             gen_en,
    output logic [AW-1:0]    src_start,
    output logic [AW-1:0]    dst_start,
    output ctl_t             ctl_prog,
    output logic [CNT_W-1:0] len_prog,
    output cfg_t             cfg,
    output logic             link_zero,
    output logic             start_req,
    output logic             clr_blk,
    output logic             sw_src,
    output logic             sw_dst,
    output logic             blk_sts,
    output logic             xfer_sts
);

    logic [31:0] link_q;
    logic        hit_clr;
    logic        hit_sw;

    assign hit_clr   = we && (waddr == RG_ICLR);
    assign hit_sw    = we && (waddr == RG_SWREQ);
    assign clr_blk   = hit_clr && wdata[0];
    assign start_req = we && (waddr == RG_CHEN) && wdata[0] && gen_en;
    assign link_zero = (link_q == 32'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en    <= 1'b0;
            src_start <= '0;
            dst_start <= '0;
            ctl_prog  <= '0;
            len_prog  <= '0;
            cfg       <= '0;
            link_q    <= '0;
        end else if (we) begin
            case (waddr)
                RG_GEN: gen_en    <= wdata[0];
                RG_SRC: src_start <= wdata[AW-1:0];
                RG_DST: dst_start <= wdata[AW-1:0];
                RG_CTL: begin
                    ctl_prog.src_w  <= wdata[1:0];
                    ctl_prog.dst_w  <= wdata[3:2];
                    ctl_prog.src_m  <= wdata[5:4];
                    ctl_prog.dst_m  <= wdata[7:6];
                    ctl_prog.int_en <= wdata[8];
                    len_prog        <= wdata[16 +: CNT_W];
                end
                RG_CFG: begin
                    cfg.src_sw     <= wdata[0];
                    cfg.dst_sw     <= wdata[1];
                    cfg.rl_src     <= wdata[2];
                    cfg.rl_dst     <= wdata[3];
                    cfg.blk_unmask <= wdata[4];
                end
                RG_LINK: link_q <= wdata;
                default: ;
            endcase
        end
    end

    // status and software request flops: a set in the same cycle wins
    always_ff @(posedge clk) begin
        if (rst) begin
            blk_sts  <= 1'b0;
            xfer_sts <= 1'b0;
            sw_src   <= 1'b0;
            sw_dst   <= 1'b0;
        end else begin
            blk_sts  <= (blk_sts  & ~(hit_clr & wdata[0])) | set_blk;
            xfer_sts <= (xfer_sts & ~(hit_clr & wdata[1])) | set_xfer;
            sw_src   <= (sw_src & ~use_sw_src) | (hit_sw & wdata[0]);
            sw_dst   <= (sw_dst & ~use_sw_dst) | (hit_sw & wdata[1]);
        end
    end

endmodule

// File: rtl/dmar_addr_gen.sv
module dmar_addr_gen
    import dmar_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          advance,
    input  logic [1:0]    width,
    input  logic [1:0]    mode,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] step;

    assign step = AW'(beat_bytes(width));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (advance) begin
            case (mode)
                AM_INC:  addr <= addr + step;
                AM_DEC:  addr <= addr - step;
                default: addr <= addr;
            endcase
        end
    end

endmodule

// File: rtl/dmar_seq.sv
module dmar_seq
    import dmar_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             both_ok,
    input  logic             mem_ready,
    input  logic [CNT_W-1:0] blk_len,
    input  logic             reload_ok,
    input  logic             stall_en,
    input  logic             blk_clr,
    output chan_state_e      state,
    output logic             active,
    output logic             load,
    output logic             advance,
    output logic             capture,
    output logic             set_blk,
    output logic             set_xfer
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic             last_q;

    assign cnt_nx   = CNT_W'(cnt + 1'b1);
    assign load     = ((state == ST_IDLE) && start_req) || ((state == ST_END) && reload_ok);
    assign advance  = (state == ST_WR) && mem_ready;
    assign capture  = (state == ST_RD) && mem_ready;
    assign set_blk  = (state == ST_END);
    assign set_xfer = (state == ST_END) && !reload_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            active <= 1'b0;
            cnt    <= '0;
            last_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start_req) begin
                    state  <= ST_WAIT;
                    active <= 1'b1;
                    cnt    <= '0;
                end
                ST_WAIT: if (both_ok) state <= ST_RD;
                ST_RD:   if (mem_ready) state <= ST_WR;
                ST_WR:   if (mem_ready) begin
                    state  <= ST_ACK;
                    cnt    <= cnt_nx;
                    last_q <= (cnt_nx == blk_len);
                end
                ST_ACK:  state <= last_q ? ST_END : ST_WAIT;
                ST_END:  if (reload_ok) begin
                    cnt   <= '0;
                    state <= stall_en ? ST_STALL : ST_WAIT;
                end else begin
                    state  <= ST_IDLE;
                    active <= 1'b0;
                end
                ST_STALL: if (blk_clr) state <= ST_WAIT;
                default:  state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dmar_reload_chan.sv
module dmar_reload_chan
    import dmar_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    input  logic          src_hreq,
    output logic          src_hack,
    input  logic          dst_hreq,
    output logic          dst_hack,
    output logic          ch_active,
    output logic          irq_block,
    output logic          irq_xfer
);

    ctl_t             ctl_prog, ctl_w;
    cfg_t             cfg;
    logic [CNT_W-1:0] len_prog, len_w;
    logic [AW-1:0]    src_start, dst_start, src_addr, dst_addr;
    logic             gen_en, link_zero, start_req, clr_blk;
    logic             sw_src, sw_dst, use_sw_src, use_sw_dst;
    logic             src_ok, dst_ok, both_ok, take;
    logic             reload_ok, stall_en;
    logic             load, advance, capture, set_blk, set_xfer;
    logic [DW-1:0]    data_q;
    chan_state_e      seq_state;

    dmar_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
        .set_blk(set_blk), .set_xfer(set_xfer),
        .use_sw_src(use_sw_src), .use_sw_dst(use_sw_dst),
        .gen_en(gen_en), .src_start(src_start), .dst_start(dst_start),
        .ctl_prog(ctl_prog), .len_prog(len_prog), .cfg(cfg), .link_zero(link_zero),
        .start_req(start_req), .clr_blk(clr_blk), .sw_src(sw_src), .sw_dst(sw_dst),
        .blk_sts(irq_block), .xfer_sts(irq_xfer)
    );

    assign src_ok     = cfg.src_sw ? sw_src : src_hreq;
    assign dst_ok     = cfg.dst_sw ? sw_dst : dst_hreq;
    assign both_ok    = src_ok && dst_ok;
    assign take       = (seq_state == ST_WAIT) && both_ok;
    assign use_sw_src = take && cfg.src_sw;
    assign use_sw_dst = take && cfg.dst_sw;
    assign reload_ok  = cfg.rl_src && cfg.rl_dst && link_zero;
    assign stall_en   = ctl_w.int_en && cfg.blk_unmask;

    dmar_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .start_req(start_req), .both_ok(both_ok),
        .mem_ready(mem_ready), .blk_len(len_w), .reload_ok(reload_ok),
        .stall_en(stall_en), .blk_clr(clr_blk), .state(seq_state),
        .active(ch_active), .load(load), .advance(advance), .capture(capture),
        .set_blk(set_blk), .set_xfer(set_xfer)
    );

    // working copy of the control word, restored on every start or reload
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_w <= '0;
            len_w <= '0;
        end else if (load) begin
            ctl_w <= ctl_prog;
            len_w <= len_prog;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          data_q <= '0;
        else if (capture) data_q <= mem_rdata;
    end

    generate
        for (genvar s = 0; s < 2; s++) begin : g_side
            if (s == 0) begin : g_src
                dmar_addr_gen #(.AW(AW)) u_ag (
                    .clk(clk), .rst(rst), .load(load), .load_val(src_start),
                    .advance(advance), .width(ctl_w.src_w), .mode(ctl_w.src_m),
                    .addr(src_addr)
                );
            end else begin : g_dst
                dmar_addr_gen #(.AW(AW)) u_ag (
                    .clk(clk), .rst(rst), .load(load), .load_val(dst_start),
                    .advance(advance), .width(ctl_w.dst_w), .mode(ctl_w.dst_m),
                    .addr(dst_addr)
                );
            end
        end
    endgenerate

    assign mem_req   = (seq_state == ST_RD) || (seq_state == ST_WR);
    assign mem_we    = (seq_state == ST_WR);
    assign mem_addr  = mem_we ? dst_addr : src_addr;
    assign mem_size  = mem_we ? ctl_w.dst_w : ctl_w.src_w;
    assign mem_wdata = data_q;
    assign src_hack  = (seq_state == ST_ACK) && !cfg.src_sw;
    assign dst_hack  = (seq_state == ST_ACK) && !cfg.dst_sw;

endmodule

// File: rtl/dmar_chk.sv
module dmar_chk (
    input logic clk,
    input logic rst,
    input logic mem_req,
    input logic mem_we,
    input logic ch_active,
    input logic gen_en,
    input logic in_stall,
    input logic src_hack,
    input logic dst_hack,
    input logic irq_xfer
);

    a_r1_no_start_when_off: assert property (@(posedge clk) disable iff (rst)
        (!gen_en && !ch_active) |=> !ch_active);

    a_r10_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !ch_active |-> !mem_req);

    a_r11_write_is_request: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    a_r5_src_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        src_hack |=> !src_hack);

    a_r5_dst_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        dst_hack |=> !dst_hack);

    a_r7_stall_quiet: assert property (@(posedge clk) disable iff (rst)
        in_stall |-> !mem_req);

    a_r8_end_sets_xfer: assert property (@(posedge clk) disable iff (rst)
        $fell(ch_active) |-> irq_xfer);

endmodule

bind dmar_reload_chan dmar_chk u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
    .ch_active(ch_active), .gen_en(gen_en),
    .in_stall(seq_state == dmar_pkg::ST_STALL),
    .src_hack(src_hack), .dst_hack(dst_hack), .irq_xfer(irq_xfer)
);

// File: tb/sim_dmar_reload_chan.sv
module sim_dmar_reload_chan;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CNT_W = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          mem_ready = 1'b1;
    logic          src_hreq = 1'b1, dst_hreq = 1'b1;
    logic          src_hack, dst_hack, ch_active, irq_block, irq_xfer;

    int n_chk = 0, n_bad = 0;
    int n_rd = 0, n_wr = 0, n_sack = 0, n_dack = 0;
    bit slow = 1'b0;
    bit done = 1'b0;
    int phase = 0;

    logic [AW-1:0] rd_q[$];
    logic [AW-1:0] wa_q[$];
    logic [DW-1:0] wd_q[$];
    logic [1:0]    rs_q[$];
    logic [1:0]    ws_q[$];

    always #4 clk = ~clk;

    dmar_reload_chan #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .src_hreq(src_hreq), .src_hack(src_hack), .dst_hreq(dst_hreq), .dst_hack(dst_hack),
        .ch_active(ch_active), .irq_block(irq_block), .irq_xfer(irq_xfer)
    );

    // memory model: read data is a pure function of the address
    assign mem_rdata = {16'hA55A, mem_addr};

    always begin
        @(posedge clk);
        #1;
        phase = phase + 1;
        mem_ready = slow ? ((phase % 3) == 2) : 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [1:0] w,
                                         input logic [1:0] m);
        int b;
        b = (w == 2'd0) ? 1 : ((w == 2'd1) ? 2 : 4);
        if (m == 2'd0)      return a + AW'(b);
        else if (m == 2'd1) return a - AW'(b);
        else                return a;
    endfunction

    task automatic expect_block(input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                                input logic [1:0] sw, input logic [1:0] dw,
                                input logic [1:0] sm, input logic [1:0] dm, input int n);
        logic [AW-1:0] s, d;
        s = s0;
        d = d0;
        for (int i = 0; i < n; i++) begin
            rd_q.push_back(s);
            rs_q.push_back(sw);
            wa_q.push_back(d);
            ws_q.push_back(dw);
            wd_q.push_back({16'hA55A, s});
            s = nxt(s, sw, sm);
            d = nxt(d, dw, dm);
        end
    endtask

    // per-clock comparison against the expected beat stream
    always @(negedge clk) begin
        if (!rst) begin
            if (src_hack) n_sack++;
            if (dst_hack) n_dack++;
            if (mem_req && mem_ready) begin
                if (!mem_we) begin
                    n_rd++;
                    if (rd_q.size() == 0) chk("R11 unexpected read", 32'(mem_addr), 32'hFFFF_FFFF);
                    else begin
                        chk("R3 read address", 32'(mem_addr), 32'(rd_q.pop_front()));
                        chk("R2 read size", 32'(mem_size), 32'(rs_q.pop_front()));
                    end
                end else begin
                    n_wr++;
                    if (wa_q.size() == 0) chk("R11 unexpected write", 32'(mem_addr), 32'hFFFF_FFFF);
                    else begin
                        chk("R3 write address", 32'(mem_addr), 32'(wa_q.pop_front()));
                        chk("R2 write size", 32'(mem_size), 32'(ws_q.pop_front()));
                        chk("R11 write data", mem_wdata, wd_q.pop_front());
                    end
                end
            end
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] mkctl(input logic [1:0] sw, input logic [1:0] dw,
                                          input logic [1:0] sm, input logic [1:0] dm,
                                          input logic ie, input int len);
        logic [31:0] c;
        c = '0;
        c[1:0] = sw;
        c[3:2] = dw;
        c[5:4] = sm;
        c[7:6] = dm;
        c[8] = ie;
        c[16 +: CNT_W] = CNT_W'(len);
        return c;
    endfunction

    task automatic clear_counts();
        n_rd = 0; n_wr = 0; n_sack = 0; n_dack = 0;
    endtask

    task automatic wait_done();
        for (int t = 0; t < 3000 && ch_active; t++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 ch_active", 32'(ch_active), 0);
        chk("R10 mem_req", 32'(mem_req), 0);
        chk("R10 irq_block", 32'(irq_block), 0);
        chk("R10 irq_xfer", 32'(irq_xfer), 0);

        // R1: start ignored while global enable is off
        wr_reg(4'd1, 32'h0000_0100);
        wr_reg(4'd2, 32'h0000_0800);
        wr_reg(4'd3, mkctl(2'd2, 2'd2, 2'd0, 2'd0, 1'b0, 4));
        wr_reg(4'd4, 32'h0);
        wr_reg(4'd5, 32'h1);
        repeat (6) @(negedge clk);
        chk("R1 ignored start ch_active", 32'(ch_active), 0);
        chk("R1 ignored start reads", 32'(n_rd), 0);

        // R11 R12 R5 R8: single word block, hardware pacing
        clear_counts();
        expect_block(16'h0100, 16'h0800, 2'd2, 2'd2, 2'd0, 2'd0, 4);
        wr_reg(4'd0, 32'h1);
        wr_reg(4'd5, 32'h1);
        chk("R1 started", 32'(ch_active), 1);
        wait_done();
        chk("R12 items written", 32'(n_wr), 4);
        chk("R11 queue drained", 32'(wa_q.size()), 0);
        chk("R5 source acks", 32'(n_sack), 4);
        chk("R5 destination acks", 32'(n_dack), 4);
        chk("R8 transfer complete", 32'(irq_xfer), 1);
        chk("R8 block complete", 32'(irq_block), 1);
        chk("R8 channel off", 32'(ch_active), 0);

        // R9: write-one-to-clear
        wr_reg(4'd6, 32'h0);
        chk("R9 zero write keeps xfer", 32'(irq_xfer), 1);
        chk("R9 zero write keeps block", 32'(irq_block), 1);
        wr_reg(4'd6, 32'h2);
        chk("R9 xfer cleared", 32'(irq_xfer), 0);
        chk("R9 block untouched", 32'(irq_block), 1);
        wr_reg(4'd6, 32'h1);
        chk("R9 block cleared", 32'(irq_block), 0);

        // R2 R3: decrementing halfword source, fixed byte destination, slow memory
        clear_counts();
        slow = 1'b1;
        expect_block(16'h0400, 16'h0900, 2'd1, 2'd0, 2'd1, 2'd2, 3);
        wr_reg(4'd1, 32'h0000_0400);
        wr_reg(4'd2, 32'h0000_0900);
        wr_reg(4'd3, mkctl(2'd1, 2'd0, 2'd1, 2'd2, 1'b0, 3));
        wr_reg(4'd5, 32'h1);
        wait_done();
        slow = 1'b0;
        chk("R12 items with slow memory", 32'(n_wr), 3);
        chk("R3 queue drained", 32'(rd_q.size()), 0);
        wr_reg(4'd6, 32'h3);

        // R4: hardware request line gates each item
        clear_counts();
        src_hreq = 1'b0;
        expect_block(16'h0200, 16'h0A00, 2'd2, 2'd2, 2'd0, 2'd0, 2);
        wr_reg(4'd1, 32'h0000_0200);
        wr_reg(4'd2, 32'h0000_0A00);
        wr_reg(4'd3, mkctl(2'd2, 2'd2, 2'd0, 2'd0, 1'b0, 2));
        wr_reg(4'd5, 32'h1);
        repeat (10) @(negedge clk);
        chk("R4 no read without source request", 32'(n_rd), 0);
        chk("R4 still active", 32'(ch_active), 1);
        src_hreq = 1'b1;
        wait_done();
        chk("R4 items after request", 32'(n_wr), 2);
        wr_reg(4'd6, 32'h3);

        // R6 R7: three reloaded blocks, interrupt enabled but masked
        clear_counts();
        for (int b = 0; b < 3; b++) expect_block(16'h0300, 16'h0C00, 2'd2, 2'd2, 2'd0, 2'd0, 4);
        wr_reg(4'd1, 32'h0000_0300);
        wr_reg(4'd2, 32'h0000_0C00);
        wr_reg(4'd3, mkctl(2'd2, 2'd2, 2'd0, 2'd0, 1'b1, 4));
        wr_reg(4'd4, 32'h0C);
        wr_reg(4'd5, 32'h1);
        for (int t = 0; t < 2000 && n_wr < 9; t++) @(negedge clk);
        chk("R6 reload keeps running", 32'(ch_active), 1);
        chk("R6 block status after reload", 32'(irq_block), 1);
        chk("R7 masked no transfer-complete", 32'(irq_xfer), 0);
        wr_reg(4'd4, 32'h0);
        wait_done();
        chk("R6 three blocks written", 32'(n_wr), 12);
        chk("R6 queue drained", 32'(wa_q.size()), 0);
        chk("R8 transfer complete after reload", 32'(irq_xfer), 1);
        wr_reg(4'd6, 32'h3);

        // R7: halt after a block until block-complete is cleared
        clear_counts();
        for (int b = 0; b < 2; b++) expect_block(16'h0500, 16'h0E00, 2'd2, 2'd2, 2'd0, 2'd0, 2);
        wr_reg(4'd1, 32'h0000_0500);
        wr_reg(4'd2, 32'h0000_0E00);
        wr_reg(4'd3, mkctl(2'd2, 2'd2, 2'd0, 2'd0, 1'b1, 2));
        wr_reg(4'd4, 32'h1C);
        wr_reg(4'd5, 32'h1);
        for (int t = 0; t < 2000 && !irq_block; t++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R7 halted item count", 32'(n_wr), 2);
        chk("R7 halted no request", 32'(mem_req), 0);
        chk("R7 halted still active", 32'(ch_active), 1);
        wr_reg(4'd4, 32'h10);
        wr_reg(4'd6, 32'h1);
        chk("R9 block cleared while halted", 32'(irq_block), 0);
        @(negedge clk);
        chk("R7 resume read issued", 32'(mem_req), 1);
        wait_done();
        chk("R7 second block written", 32'(n_wr), 4);
        chk("R8 transfer complete after halt", 32'(irq_xfer), 1);
        wr_reg(4'd6, 32'h3);

        // R6 R8: nonzero link register forces the last block
        clear_counts();
        expect_block(16'h0600, 16'h0F00, 2'd2, 2'd2, 2'd0, 2'd0, 2);
        wr_reg(4'd1, 32'h0000_0600);
        wr_reg(4'd2, 32'h0000_0F00);
        wr_reg(4'd3, mkctl(2'd2, 2'd2, 2'd0, 2'd0, 1'b0, 2));
        wr_reg(4'd4, 32'h0C);
        wr_reg(4'd8, 32'h5);
        wr_reg(4'd5, 32'h1);
        wait_done();
        chk("R8 link nonzero single block", 32'(n_wr), 2);
        chk("R8 link nonzero complete", 32'(irq_xfer), 1);
        wr_reg(4'd8, 32'h0);
        wr_reg(4'd6, 32'h3);

        // R4 R5: software pacing on both sides, request lines ignored
        clear_counts();
        expect_block(16'h0700, 16'h0B00, 2'd2, 2'd2, 2'd0, 2'd0, 3);
        wr_reg(4'd1, 32'h0000_0700);
        wr_reg(4'd2, 32'h0000_0B00);
        wr_reg(4'd3, mkctl(2'd2, 2'd2, 2'd0, 2'd0, 1'b0, 3));
        wr_reg(4'd4, 32'h03);
        wr_reg(4'd5, 32'h1);
        repeat (8) @(negedge clk);
        chk("R4 request lines ignored in software mode", 32'(n_rd), 0);
        for (int t = 0; t < 200 && ch_active; t++) begin
            wr_reg(4'd7, 32'h3);
            repeat (3) @(negedge clk);
        end
        chk("R4 software paced items", 32'(n_wr), 3);
        chk("R5 no source ack in software mode", 32'(n_sack), 0);
        chk("R5 no destination ack in software mode", 32'(n_dack), 0);
        chk("R8 software paced complete", 32'(irq_xfer), 1);

        finish_run();
    end

endmodule